// File: doc/BRIEF.md
# Bit-Serial Scalar Multiply Sequencer

This block is the control sequencer of an elliptic-curve point multiplier that works through its scalar one bit per iteration. The scalar is taken most significant bit first. Every iteration has a fixed cycle budget. Within that budget the sequencer raises single-cycle read strobes toward the three coordinate memories (X, Y, Z) at fixed offsets from the moment the bit counter moves. It then closes the iteration with an eight-cycle write burst that stores the step result back into all three memories.

When the scalar bit of an iteration is 1, an inhibit flag is raised and the write enables stay low for that burst, so the addition result is thrown away. The burst addresses still step through their full sequence. Because the cycle count does not depend on the scalar, only the write enables show the key. The field arithmetic is outside this block; a fixed-latency stub stands in for it so that the ordering between result readiness and write-back can be checked.

A scalar is loaded while the sequencer is idle, and a start pulse launches a run. A one-cycle done pulse ends the run. An absolute cycle counter and the bit counter are brought out so that every strobe can be placed in time.

Top module: `sm_scalar_seq`

## Requirements
- R1: After reset, all read strobes, write enables, `inhibit` and `done` are 0, and `wr_addr`, `bit_cnt` and `cyc_cnt` are 0.
- R2: A start pulse accepted while idle clears `cyc_cnt` to 0 on that edge. `cyc_cnt` then rises by one every cycle up to and including the cycle of `done`, and holds afterwards.
- R3: `bit_cnt` becomes 0 at `cyc_cnt` = INIT_DELAY (42). It rises by one every BIT_CYCLES (4204) cycles, for SCALAR_W (256) iterations.
- R4: With s the cycles elapsed since the last `bit_cnt` update, `rd_z` is high only at s = 17, `rd_x` only at s = 205 and `rd_y` only at s = 473, each for one cycle per iteration.
- R5: `wr_en_x`, `wr_en_y` and `wr_en_z` rise together, for 8 consecutive cycles at s = BIT_CYCLES-9 through BIT_CYCLES-2 (4195..4202). One idle cycle follows before `bit_cnt` advances.
- R6: During the burst, `wr_addr` counts 0,1,...,7, one step per cycle. Outside the burst it is 0.
- R7: Iteration i (`bit_cnt` = i) uses scalar bit SCALAR_W-1-i, so the scalar is taken MSB first. `inhibit` equals that bit for the whole iteration and is 0 when no iteration is running.
- R8: When the iteration's scalar bit is 1, the three write enables stay low for the whole burst, while `wr_addr` still counts 0..7.
- R9: `done` is high for exactly one cycle, at `cyc_cnt` = INIT_DELAY + SCALAR_W*BIT_CYCLES. The sequencer is idle afterwards.
- R10: A `start` or `load_en` while a run is in progress has no effect on the counters, strobes or inhibit pattern of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch pulse, honoured only while idle |
| load_en | input | 1 | Capture `load_scalar` while idle |
| load_scalar | input | SCALAR_W | Scalar value, bit SCALAR_W-1 processed first |
| rd_x | output | 1 | X memory read strobe |
| rd_y | output | 1 | Y memory read strobe |
| rd_z | output | 1 | Z memory read strobe |
| wr_en_x | output | 1 | X memory write enable |
| wr_en_y | output | 1 | Y memory write enable |
| wr_en_z | output | 1 | Z memory write enable |
| wr_addr | output | ADDR_W | Write address within the burst |
| inhibit | output | 1 | Current scalar bit is 1; addition write-back discarded |
| bit_cnt | output | BIT_W | Iteration index, 0 first |
| cyc_cnt | output | CYC_W | Cycles since the accepted start |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach from the ports is a start or scalar load arriving in the middle of a run. The hazard is that it silently restarts the counters or changes the inhibit pattern of the bits that remain. The bench fires both at once, with the inverted scalar, deep inside an iteration. It then keeps comparing every cycle of the rest of the run against the pattern of the scalar loaded originally. The bench model is written independently of the RTL and uses an asymmetric scalar. A bit-order reversal, an off-by-one burst window or a shifted read offset therefore shows up as a mismatch at a specific absolute cycle.

// File: rtl/sm_seq_pkg.sv
package sm_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sm_step_timer.sv
module sm_step_timer
  import sm_seq_pkg::*;
#(
  parameter int SCALAR_W   = 256,
  parameter int BIT_CYCLES = 4204,
  parameter int INIT_DELAY = 42,
  parameter int CYC_W      = 21,
  parameter int STEP_W     = 13,
  parameter int BIT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              run,
  output logic [CYC_W-1:0]  cyc_cnt,
  output logic [STEP_W-1:0] step,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic              done
);
  localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(BIT_CYCLES - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST   = BIT_W'(SCALAR_W - 1);
  localparam logic [CYC_W-1:0]  SETUP_LAST = CYC_W'(INIT_DELAY - 1);

  seq_state_e        state_q, state_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              done_q, done_d;
  logic              cyc_en;

  assign cyc_en = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    step_d  = step_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    if (cyc_en) cyc_d = cyc_q + 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          cyc_d   = '0;
          step_d  = '0;
          bit_d   = '0;
        end
      end
      ST_SETUP: begin
        if (cyc_q == SETUP_LAST) begin
          state_d = ST_RUN;
          step_d  = '0;
          bit_d   = '0;
        end
      end
      ST_RUN: begin
        if (step_q == STEP_LAST) begin
          step_d = '0;
          if (bit_q == BIT_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      step_q  <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cyc_q   <= cyc_d;
      step_q  <= step_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign run     = (state_q == ST_RUN);
  assign cyc_cnt = cyc_q;
  assign step    = step_q;
  assign bit_cnt = bit_q;
  assign done    = done_q;

  // R2
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cyc_q == $past(cyc_q) + 1'b1));

  // R3
  bit_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_q == STEP_LAST && bit_q != BIT_LAST) |=> (run && bit_q == $past(bit_q) + 1'b1 && step_q == '0));

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_q != STEP_LAST) |=> $stable(bit_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cyc_q != '0));
endmodule

// File: rtl/sm_strobe_gen.sv
module sm_strobe_gen #(
  parameter int BIT_CYCLES = 4204,
  parameter int RD_OFS_X   = 205,
  parameter int RD_OFS_Y   = 473,
  parameter int RD_OFS_Z   = 17,
  parameter int BURST_LEN  = 8,
  parameter int STEP_W     = 13,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [STEP_W-1:0] step,
  input  logic              kbit,
  output logic [2:0]        rd_stb,
  output logic [2:0]        wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              inhibit
);
  localparam int BURST_FIRST = BIT_CYCLES - BURST_LEN - 1;
  localparam int BURST_END   = BURST_FIRST + BURST_LEN;
  localparam logic [STEP_W-1:0] B_LO = STEP_W'(BURST_FIRST);
  localparam logic [STEP_W-1:0] B_HI = STEP_W'(BURST_END);
  localparam int RD_OFS [3] = '{RD_OFS_X, RD_OFS_Y, RD_OFS_Z};

  logic              in_burst;
  logic [STEP_W-1:0] rel;

  for (genvar g = 0; g < 3; g++) begin : g_rd
    assign rd_stb[g] = run && (step == STEP_W'(RD_OFS[g]));
  end

  assign in_burst = run && (step >= B_LO) && (step < B_HI);
  assign rel      = step - B_LO;
  assign inhibit  = run && kbit;
  assign wr_addr  = in_burst ? rel[ADDR_W-1:0] : '0;

  for (genvar g = 0; g < 3; g++) begin : g_wr
    assign wr_en[g] = in_burst && !kbit;
  end

  // R4
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_stb));

  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb != 3'b000) |=> (rd_stb == 3'b000));

  // R5
  wr_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == 3'b000) || (wr_en == 3'b111));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && wr_addr != ADDR_W'(BURST_LEN - 1)) |=> (wr_addr == $past(wr_addr) + 1'b1));

  // R8
  inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (wr_en == 3'b000));

  // R5
  burst_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && wr_addr != ADDR_W'(BURST_LEN - 1)) |=> wr_en[0]);
endmodule

// File: rtl/sm_arith_stub.sv
module sm_arith_stub #(
  parameter int LATENCY = 4100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic rdy
);
  localparam int LAT_W = $clog2(LATENCY + 1);
  localparam logic [LAT_W-1:0] LAT_V = LAT_W'(LATENCY);

  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d;
  logic             cnt_en;

  assign cnt_en = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    arm_d = arm_q;
    if (kick) begin
      cnt_d = LAT_V;
      arm_d = 1'b1;
    end else if (cnt_en) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  assign rdy = arm_q && !cnt_en;

  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !rdy);
endmodule

// File: rtl/sm_scalar_seq.sv
module sm_scalar_seq
  import sm_seq_pkg::*;
#(
  parameter int SCALAR_W   = 256,
  parameter int BIT_CYCLES = 4204,
  parameter int INIT_DELAY = 42,
  parameter int RD_OFS_X   = 205,
  parameter int RD_OFS_Y   = 473,
  parameter int RD_OFS_Z   = 17,
  parameter int BURST_LEN  = 8,
  parameter int ARITH_LAT  = 4100,
  localparam int CYC_W     = $clog2(INIT_DELAY + SCALAR_W * BIT_CYCLES + 2),
  localparam int STEP_W    = $clog2(BIT_CYCLES),
  localparam int BIT_W     = (SCALAR_W > 1) ? $clog2(SCALAR_W) : 1,
  localparam int ADDR_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                load_en,
  input  logic [SCALAR_W-1:0] load_scalar,
  output logic                rd_x,
  output logic                rd_y,
  output logic                rd_z,
  output logic                wr_en_x,
  output logic                wr_en_y,
  output logic                wr_en_z,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic                inhibit,
  output logic [BIT_W-1:0]    bit_cnt,
  output logic [CYC_W-1:0]    cyc_cnt,
  output logic                done
);
  logic [1:0]          rst_sync_q;
  logic                rst_i_n;
  logic [SCALAR_W-1:0] scalar_q, scalar_d;
  logic                scalar_en;
  logic                busy, run, kbit, arith_rdy, kick;
  logic [STEP_W-1:0]   step;
  logic [BIT_W-1:0]    bit_idx;
  logic [2:0]          rd_stb, wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign scalar_en = load_en && !busy;
  assign scalar_d  = load_scalar;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       scalar_q <= '0;
    else if (scalar_en) scalar_q <= scalar_d;
  end

  sm_step_timer #(
    .SCALAR_W  (SCALAR_W),
    .BIT_CYCLES(BIT_CYCLES),
    .INIT_DELAY(INIT_DELAY),
    .CYC_W     (CYC_W),
    .STEP_W    (STEP_W),
    .BIT_W     (BIT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .start  (start),
    .busy   (busy),
    .run    (run),
    .cyc_cnt(cyc_cnt),
    .step   (step),
    .bit_cnt(bit_cnt),
    .done   (done)
  );

  assign bit_idx = BIT_W'(SCALAR_W - 1) - bit_cnt;
  assign kbit    = scalar_q[bit_idx];
  assign kick    = run && (step == '0);

  sm_arith_stub #(
    .LATENCY(ARITH_LAT)
  ) u_arith (
    .clk  (clk),
    .rst_n(rst_i_n),
    .kick (kick),
    .rdy  (arith_rdy)
  );

  sm_strobe_gen #(
    .BIT_CYCLES(BIT_CYCLES),
    .RD_OFS_X  (RD_OFS_X),
    .RD_OFS_Y  (RD_OFS_Y),
    .RD_OFS_Z  (RD_OFS_Z),
    .BURST_LEN (BURST_LEN),
    .STEP_W    (STEP_W),
    .ADDR_W    (ADDR_W)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run    (run),
    .step   (step),
    .kbit   (kbit),
    .rd_stb (rd_stb),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .inhibit(inhibit)
  );

  assign rd_x    = rd_stb[0];
  assign rd_y    = rd_stb[1];
  assign rd_z    = rd_stb[2];
  assign wr_en_x = wr_en[0];
  assign wr_en_y = wr_en[1];
  assign wr_en_z = wr_en[2];

  // R10
  scalar_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |=> $stable(scalar_q));

  // R5
  result_ready_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_en != 3'b000) |-> arith_rdy);

  // R7
  inhibit_bit_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (run && step != '0) |-> $stable(inhibit));
endmodule

// File: tb/sim_sm_scalar_seq.sv
`timescale 1ns/1ps
module sim_sm_scalar_seq;
  localparam int W    = 8;
  localparam int BC   = 600;
  localparam int INIT = 42;
  localparam int OX   = 205;
  localparam int OY   = 473;
  localparam int OZ   = 17;
  localparam int BL   = 8;
  localparam int CYC_W  = $clog2(INIT + W * BC + 2);
  localparam int BIT_W  = $clog2(W);
  localparam int ADDR_W = $clog2(BL);
  localparam int TOTAL  = INIT + W * BC;

  logic clk = 1'b0;
  logic rst_n, start, load_en;
  logic [W-1:0] load_scalar;
  logic rd_x, rd_y, rd_z, wr_en_x, wr_en_y, wr_en_z, inhibit, done;
  logic [ADDR_W-1:0] wr_addr;
  logic [BIT_W-1:0]  bit_cnt;
  logic [CYC_W-1:0]  cyc_cnt;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sm_scalar_seq #(
    .SCALAR_W(W), .BIT_CYCLES(BC), .INIT_DELAY(INIT),
    .RD_OFS_X(OX), .RD_OFS_Y(OY), .RD_OFS_Z(OZ),
    .BURST_LEN(BL), .ARITH_LAT(500)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .load_en(load_en),
    .load_scalar(load_scalar), .rd_x(rd_x), .rd_y(rd_y), .rd_z(rd_z),
    .wr_en_x(wr_en_x), .wr_en_y(wr_en_y), .wr_en_z(wr_en_z),
    .wr_addr(wr_addr), .inhibit(inhibit), .bit_cnt(bit_cnt),
    .cyc_cnt(cyc_cnt), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; load_en = 1'b0; load_scalar = '0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk({rd_x, rd_y, rd_z, wr_en_x, wr_en_y, wr_en_z, inhibit, done} == '0, "R1 strobes", 1, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cyc_cnt == '0, "R1 cyc_cnt", cyc_cnt, 0);
    chk(bit_cnt == '0, "R1 bit_cnt", bit_cnt, 0);
    chk(wr_addr == '0, "R1 wr_addr", wr_addr, 0);
    chk({rd_x, rd_y, rd_z, wr_en_x, wr_en_y, wr_en_z, inhibit, done} == '0, "R1 idle", 1, 0);
  endtask

  // One full run of scalar k; poke injects start + load of ~k mid-run (R10)
  task automatic run_scalar(input logic [W-1:0] k, input bit poke);
    @(negedge clk);
    load_en = 1'b1; load_scalar = k;
    @(negedge clk);
    load_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= TOTAL + 1; t++) begin
      bit in_run, kb, inb, exp_wr;
      int b, s, exp_addr;
      in_run = (t >= INIT) && (t < TOTAL);
      b = in_run ? (t - INIT) / BC : 0;
      s = in_run ? (t - INIT) % BC : 0;
      kb = in_run ? k[W - 1 - b] : 1'b0;
      inb = in_run && (s >= BC - BL - 1) && (s <= BC - 2);
      exp_wr = inb && !kb;
      exp_addr = inb ? s - (BC - BL - 1) : 0;
      // R2
      chk(int'(cyc_cnt) == ((t <= TOTAL) ? t : TOTAL), "R2 cyc_cnt", cyc_cnt, t);
      // R3
      if (in_run) chk(int'(bit_cnt) == b, "R3 bit_cnt", bit_cnt, b);
      // R4
      chk(rd_z == (in_run && s == OZ), "R4 rd_z", rd_z, in_run && s == OZ);
      chk(rd_x == (in_run && s == OX), "R4 rd_x", rd_x, in_run && s == OX);
      chk(rd_y == (in_run && s == OY), "R4 rd_y", rd_y, in_run && s == OY);
      // R5 / R8
      chk(wr_en_x == exp_wr && wr_en_y == exp_wr && wr_en_z == exp_wr,
          kb ? "R8 wr_en inhibited" : "R5 wr_en burst", {wr_en_x, wr_en_y, wr_en_z}, {3{exp_wr}});
      // R6
      chk(int'(wr_addr) == exp_addr, "R6 wr_addr", wr_addr, exp_addr);
      // R7
      chk(inhibit == kb, "R7 inhibit", inhibit, kb);
      // R9
      chk(done == (t == TOTAL), "R9 done", done, t == TOTAL);
      if (poke && t == 1000) begin
        start = 1'b1; load_en = 1'b1; load_scalar = ~k;
      end else if (poke && t == 1001) begin
        start = 1'b0; load_en = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    run_scalar(8'b1011_0110, 1'b0);  // R7 asymmetric MSB-first pattern
    run_scalar(8'h00, 1'b0);         // R5 every burst written
    run_scalar(8'hFF, 1'b0);         // R8 every burst inhibited
    run_scalar(8'h5A, 1'b1);         // R10 start/load while busy
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule